// File: doc/BRIEF.md
# Embedded Operation Status Engine

This block carries out the self-timed program and erase operations of a small register-based flash array model, and it reports their progress to a host that polls the device. A command decoder sits in front of it. The decoder hands over one request at a time: a word program, a sector erase or a chip erase. The engine latches the request, holds a busy flag for a fixed number of clock cycles, and applies the result to the array when the count runs out. An erase sets every bit of the chosen region to one. A program can only clear bits.

While an operation runs, a read does not return array contents. It returns a status word:
- Bit 7 carries polling information. During a program it is the inverse of bit 7 of the word being written. During an erase it is zero.
- Bit 6 flips once for every new read access.
- All other bits are zero.

A new access starts when the read strobe rises. Holding the strobe high across several clocks counts as one access. Once the operation has finished, reads return array data again and bit 6 stops changing.

A reset that arrives during a program aborts it. The target word is left partly programmed.

Top module: `ose_engine`

## Requirements
- R1: While rst_n is low at a clock edge, busy and rd_data are both zero at the next sample.
- R2: A request with req_valid high and req_op not 0, taken while busy is low, raises busy on the next cycle. Busy then stays high for exactly PROG_CYCLES cycles for a program (req_op=1), or exactly ERASE_CYCLES cycles for a sector erase (req_op=2) or a chip erase (req_op=3).
- R3: A request made while busy is high is ignored, and so is a request with req_op=0. Neither changes the array or the running operation.
- R4: When a program completes, the word at the latched address becomes its old value ANDed with the programmed data.
- R5: While a program is running, a read returns a word whose bit 7 is the inverse of bit 7 of the programmed data. Bit 6 is the toggle bit and all other bits are zero.
- R6: While a sector erase or a chip erase is running, bit 7 of a read is zero. Bit 6 is the toggle bit and all other bits are zero.
- R7: The toggle bit starts at 0 after reset and inverts once per read access. An access is a rising edge of rd_en taken while busy. The toggle bit holds its value while busy is low.
- R8: When a sector erase completes, every word whose address shares the upper address bits above log2(SECT_WORDS) with the request address reads 16'hFFFF. All other words are unchanged. With the defaults, the sector is addr[5:4].
- R9: When a chip erase completes, every word reads 16'hFFFF.
- R10: rd_data is registered with one cycle of latency. When busy is low and rd_en is high, it returns the array word at rd_addr. When rd_en is low, it returns zero.
- R11: A reset taken during a program ends the operation, and busy drops. The target word becomes old AND (data OR 16'hFF00), so only the low byte of the data takes effect. A reset taken during an erase leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; aborts a running operation |
| req_valid | input | 1 | Request strobe from the command decoder |
| req_op | input | 2 | Operation: 0 none, 1 program, 2 sector erase, 3 chip erase |
| req_addr | input | AW | Word address (program) or any address in the sector (sector erase) |
| req_data | input | 16 | Data to program |
| rd_en | input | 1 | Combined chip-enable and output-enable read strobe |
| rd_addr | input | AW | Read address |
| rd_data | output | 16 | Read data or status word, registered |
| busy | output | 1 | High while an operation is running |

## Verification
The bench goes after the following corner cases:
- It holds the read strobe high across several clocks while busy. A toggle that advanced once per clock instead of once per access would show up as a mismatch in bit 6.
- It programs over an already-programmed word. A design that overwrote the word instead of ANDing into it would return the new data.
- It fires a chip erase in the middle of a program. An engine that accepted it would wipe the array.
- It resets during a program and again during a sector erase. A design that finished the program, skipped the partial write, or cleared the sector on abort would read back the wrong word.
- It reads right at the completion edge. A status path that was off by one cycle would leak array data or stale status at that point.

// File: rtl/ose_pkg.sv
package ose_pkg;

  localparam int unsigned WORD_W = 16;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  // program may only clear bits
  function automatic word_t prog_merge(word_t old_w, word_t new_w);
    return old_w & new_w;
  endfunction

  // aborted program: only the low byte of the new data has reached the cells
  function automatic word_t abort_merge(word_t old_w, word_t new_w);
    word_t hi_keep;
    hi_keep = ~word_t'(8'hFF);
    return old_w & (new_w | hi_keep);
  endfunction

  // word returned on a read while an operation is running
  function automatic word_t status_word(op_e op, logic src7, logic tgl);
    word_t w;
    w    = '0;
    w[7] = (op == OP_PROG) ? ~src7 : 1'b0;
    w[6] = tgl;
    return w;
  endfunction

endpackage

// File: rtl/ose_seq.sv
module ose_seq
  import ose_pkg::*;
#(
  parameter int unsigned AW           = 6,
  parameter int unsigned PROG_CYCLES  = 20,
  parameter int unsigned ERASE_CYCLES = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  op_e           req_op,
  input  logic [AW-1:0] req_addr,
  input  word_t         req_data,
  output logic          busy,
  output op_e           cur_op,
  output logic [AW-1:0] cur_addr,
  output word_t         cur_data,
  output logic          op_done,
  output logic          op_abort
);

  localparam int unsigned MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic          start;

  function automatic logic [CW-1:0] load_value(op_e op);
    return (op == OP_PROG) ? CW'(PROG_CYCLES - 1) : CW'(ERASE_CYCLES - 1);
  endfunction

  assign start    = req_valid && !busy && (req_op != OP_NONE);
  assign op_done  = rst_n && busy && (cnt_q == '0);
  assign op_abort = !rst_n && busy && (cur_op == OP_PROG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt_q    <= '0;
      cur_op   <= OP_NONE;
      cur_addr <= '0;
      cur_data <= '0;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - CW'(1);
    end else if (start) begin
      busy     <= 1'b1;
      cnt_q    <= load_value(req_op);
      cur_op   <= req_op;
      cur_addr <= req_addr;
      cur_data <= req_data;
    end
  end

endmodule

// File: rtl/ose_array.sv
module ose_array
  import ose_pkg::*;
#(
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned SECT_WORDS = 16,
  parameter int unsigned AW         = 6
) (
  input  logic          clk,
  input  logic          op_done,
  input  logic          op_abort,
  input  op_e           cur_op,
  input  logic [AW-1:0] cur_addr,
  input  word_t         cur_data,
  input  logic [AW-1:0] rd_addr,
  output word_t         rd_word
);

  localparam int unsigned SW = $clog2(SECT_WORDS);

  word_t rows [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam logic [AW-1:0] IDX = AW'(i);
    logic  sel_word;
    logic  sel_sect;
    word_t word_q;

    assign sel_word = (cur_addr == IDX);
    assign sel_sect = (cur_op == OP_CHIP) ||
                      ((cur_op == OP_SECT) && (IDX[AW-1:SW] == cur_addr[AW-1:SW]));

    // cells are non-volatile: no reset
    always_ff @(posedge clk) begin
      if (op_done && sel_sect)
        word_q <= '1;
      else if (op_done && (cur_op == OP_PROG) && sel_word)
        word_q <= prog_merge(word_q, cur_data);
      else if (op_abort && sel_word)
        word_q <= abort_merge(word_q, cur_data);
    end

    assign rows[i] = word_q;
  end

  assign rd_word = rows[rd_addr];

endmodule

// File: rtl/ose_status.sv
module ose_status
  import ose_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_en,
  input  logic  busy,
  input  op_e   cur_op,
  input  logic  poll_src,
  input  word_t array_word,
  output word_t rd_data,
  output logic  tog_bit,
  output logic  rd_access
);

  logic rd_en_q;
  logic tog_nxt;

  assign rd_access = rd_en && !rd_en_q;
  assign tog_nxt   = tog_bit ^ (rd_access && busy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_en_q <= 1'b0;
      tog_bit <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_en_q <= rd_en;
      tog_bit <= tog_nxt;
      if (!rd_en)    rd_data <= '0;
      else if (busy) rd_data <= status_word(cur_op, poll_src, tog_nxt);
      else           rd_data <= array_word;
    end
  end

endmodule

// File: rtl/ose_engine.sv
module ose_engine
  import ose_pkg::*;
#(
  parameter int unsigned DEPTH        = 64,
  parameter int unsigned SECT_WORDS   = 16,
  parameter int unsigned PROG_CYCLES  = 20,
  parameter int unsigned ERASE_CYCLES = 60,
  parameter int unsigned AW           = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [AW-1:0]     req_addr,
  input  logic [WORD_W-1:0] req_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy
);

  op_e           cur_op;
  logic [AW-1:0] cur_addr;
  word_t         cur_data;
  logic          op_done;
  logic          op_abort;
  word_t         array_word;
  logic          tog_bit;
  logic          rd_access;

  ose_seq #(
    .AW(AW), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(op_e'(req_op)),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .cur_op(cur_op),
    .cur_addr(cur_addr), .cur_data(cur_data), .op_done(op_done), .op_abort(op_abort)
  );

  ose_array #(
    .DEPTH(DEPTH), .SECT_WORDS(SECT_WORDS), .AW(AW)
  ) u_array (
    .clk(clk), .op_done(op_done), .op_abort(op_abort), .cur_op(cur_op),
    .cur_addr(cur_addr), .cur_data(cur_data), .rd_addr(rd_addr), .rd_word(array_word)
  );

  ose_status u_status (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .busy(busy), .cur_op(cur_op),
    .poll_src(cur_data[7]), .array_word(array_word), .rd_data(rd_data),
    .tog_bit(tog_bit), .rd_access(rd_access)
  );

endmodule

// File: rtl/ose_engine_chk.sv
module ose_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_op,
  input logic        rd_en,
  input logic        busy,
  input logic [15:0] rd_data,
  input logic [1:0]  cur_op,
  input logic [15:0] cur_data,
  input logic        op_done,
  input logic        tog_bit
);

  p_req_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_op != 2'd0) |=> busy);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !busy);

  p_hold_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_done) |=> (busy && $stable(cur_op) && $stable(cur_data)));

  p_prog_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en && cur_op == 2'd1) |=>
      (rd_data[7] == ~$past(cur_data[7]) && rd_data[5:0] == 6'd0 && rd_data[15:8] == 8'd0));

  p_erase_poll_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en && cur_op != 2'd1) |=> (!rd_data[7] && rd_data[5:0] == 6'd0));

  p_tog_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(tog_bit));

  p_quiet_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == 16'd0));

endmodule

bind ose_engine ose_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .rd_en(rd_en), .busy(busy), .rd_data(rd_data), .cur_op(cur_op),
  .cur_data(cur_data), .op_done(op_done), .tog_bit(tog_bit)
);

// File: tb/ose_engine_test.sv
module ose_engine_test;

  localparam int PROG_N  = 20;
  localparam int ERASE_N = 60;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [5:0]  req_addr;
  logic [15:0] req_data;
  logic        rd_en;
  logic [5:0]  rd_addr;
  logic [15:0] rd_data;
  logic        busy;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    started = 0;
  bit    finished = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  ose_engine #(.PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );

  // behavioural reference model
  logic [15:0] m_mem [64];
  int          m_left = 0;
  int          m_op = 0;
  int          m_addr = 0;
  logic [15:0] m_data = 0;
  bit          m_tog = 0;
  bit          m_rdq = 0;
  logic [15:0] m_rd = 0;

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      if (m_left > 0 && m_op == 1) m_mem[m_addr] = m_mem[m_addr] & (m_data | 16'hFF00);
      m_left = 0; m_tog = 0; m_rdq = 0; m_rd = 0;
    end else begin
      if (rd_en) begin
        if (m_left > 0) begin
          if (!m_rdq) m_tog = !m_tog;
          m_rd = 16'h0;
          if (m_op == 1) m_rd[7] = !m_data[7];
          m_rd[6] = m_tog;
        end else m_rd = m_mem[rd_addr];
      end else m_rd = 0;
      m_rdq = rd_en;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin
          if (m_op == 1) m_mem[m_addr] = m_mem[m_addr] & m_data;
          else for (int j = 0; j < 64; j++)
            if (m_op == 3 || (j / 16) == (m_addr / 16)) m_mem[j] = 16'hFFFF;
        end
      end else if (req_valid && req_op != 0) begin
        m_op = req_op; m_addr = req_addr; m_data = req_data;
        m_left = (req_op == 1) ? PROG_N : ERASE_N;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      n_cmp++;
      if (rd_data !== m_rd || busy !== (m_left > 0)) begin
        n_bad++;
        $display("FAIL %s cycle compare: rd_data=%h busy=%b expected rd_data=%h busy=%b",
                 cur_req, rd_data, busy, m_rd, (m_left > 0));
      end
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0; req_op = 0;
  endtask

  task automatic rd(logic [5:0] a, int hold);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    repeat (hold) @(negedge clk);
    rd_en = 0;
  endtask

  task automatic rd_chk(logic [5:0] a, logic [15:0] exp, string req);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    check(req, rd_data, exp);
    rd_en = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy === 1'b1 && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic measure(string req, int exp);
    int n = 0;
    while (busy === 1'b1 && n < 1000) begin n++; @(negedge clk); end
    check(req, 16'(n), 16'(exp));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int j = 0; j < 64; j++) m_mem[j] = 16'h0;
    rst_n = 0; req_valid = 0; req_op = 0; req_addr = 0; req_data = 0; rd_en = 0; rd_addr = 0;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    check("R1 busy", 16'(busy), 16'h0);
    check("R1 rd_data", rd_data, 16'h0);
    rst_n = 1;

    cur_req = "R9 R6 R7";
    issue(3, 0, 0);
    rd(0, 3); rd(7, 1); @(negedge clk); rd(9, 4);
    wait_idle();
    cur_req = "R9 R10";
    for (int a = 0; a < 64; a++) rd(6'(a), 1);
    rd_chk(6'd40, 16'hFFFF, "R9");

    cur_req = "R2";
    issue(1, 6'd5, 16'h1234);
    measure("R2 program length", PROG_N);
    cur_req = "R5 R7";
    issue(1, 6'd5, 16'h0FF0);
    rd(5, 4); rd(5, 1); rd(2, 2);
    wait_idle();
    rd_chk(6'd5, 16'h0230, "R4");

    cur_req = "R3";
    issue(1, 6'd6, 16'h00FF);
    repeat (2) @(negedge clk);
    issue(3, 6'd0, 16'h0);
    wait_idle();
    rd_chk(6'd6, 16'h00FF, "R3");
    rd_chk(6'd5, 16'h0230, "R3");
    issue(0, 6'd6, 16'h0000);
    check("R3 op none", 16'(busy), 16'h0);

    cur_req = "R8";
    issue(1, 6'h21, 16'hF0F0); wait_idle();
    issue(1, 6'h11, 16'h1111); wait_idle();
    issue(2, 6'h2A, 16'h0);
    measure("R2 erase length", ERASE_N);
    rd_chk(6'h21, 16'hFFFF, "R8");
    rd_chk(6'h11, 16'h1111, "R8");
    rd_chk(6'h2F, 16'hFFFF, "R8");

    cur_req = "R7 R10";
    rd(3, 1); rd(3, 2); rd(11, 1);

    cur_req = "R11";
    issue(1, 6'h21, 16'hF0F0); wait_idle();
    issue(1, 6'h21, 16'h0F00);
    repeat (5) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R11 busy after reset", 16'(busy), 16'h0);
    rst_n = 1;
    rd_chk(6'h21, 16'hF000, "R11");
    issue(2, 6'h05, 16'h0);
    repeat (4) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    rd_chk(6'h05, 16'h0230, "R11");

    cur_req = "R6 R7";
    issue(2, 6'h30, 16'h0);
    rd(1, 1); rd(1, 3); rd(2, 1);
    wait_idle();
    rd_chk(6'h30, 16'hFFFF, "R8");
    rd_chk(6'h21, 16'hF000, "R10");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule